// File: doc/BRIEF.md
# Increment/Decrement Memory March Tester

This block is a hardware sequencer that proves every bit of every word in a RAM region can hold both a 0 and a 1. It drives a simple synchronous single-port memory and makes three linear passes over an inclusive word-address range.

- **Fill pass:** gives each word a value one greater than its offset in the region.
- **Invert pass:** reads each word back, compares it with that value and, on a match, overwrites the word with the bitwise inverse.
- **Clear pass:** reads the inverse back, compares it and, on a match, writes zero.

Each word is therefore seen once as a value and once as its complement. The region is left cleared after a clean run.

A single-cycle start request launches a run, and the bounds are captured at that moment. The first word that reads back wrong stops the run, and the block keeps four items for diagnosis:

- the word address;
- the value it expected;
- the value it got;
- the pass it was in.

A one-cycle completion pulse marks the end of every run. A sticky passed or failed flag holds the outcome until the next run is launched. The test is destructive: whatever the region held before is lost.

Top module: `mem_march_tester`

## Requirements
- R1: A run covers the words from the captured low bound through the captured high bound inclusive, stepping the address by one modulo 2^ADDR_W, so the region holds ((high - low) mod 2^ADDR_W) + 1 words and a high bound below the low bound wraps through address zero.
- R2: Fill pass (fail_phase code 1): starting the cycle after start is accepted, one write per cycle is issued (mem_en=1, mem_we=1), and the word at offset k receives (k+1) mod 2^DATA_W, in increasing offset order.
- R3: Invert pass (code 2): each word takes two cycles, a read (mem_en=1, mem_we=0) and then a check cycle in which mem_rdata is compared with (k+1) mod 2^DATA_W. On a match, that same check cycle writes the bitwise inverse to the same address.
- R4: Clear pass (code 3): as R3, except that the expected value is the bitwise inverse of (k+1) mod 2^DATA_W and the write on a match is zero.
- R5: On the first mismatch, no write is issued in that check cycle and the run ends. fail_addr, fail_expected, fail_actual and fail_phase (2 or 3) hold the failing word's address, the expected value, the value read and the pass code.
- R6: done is high for exactly one cycle, in the cycle after the final check cycle of a run (passing or failing). busy is high from the cycle after start is accepted up to and including that final check cycle, and is low from the done cycle on.
- R7: passed and failed are never both high. They are cleared when a start is accepted, together with the four failure fields (which read zero). One of them is set with done and then held until the next accepted start.
- R8: start, and any change of the bound inputs, has no effect while busy is high.
- R9: After a passing run, every word of the region holds zero.
- R10: After reset, busy, done, passed, failed and mem_en are all low.
- R11: mem_en is low whenever busy is low. Read data is taken exactly one cycle after the read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch request, accepted only while idle |
| region_lo | input | ADDR_W | First word address of the region |
| region_hi | input | ADDR_W | Last word address of the region |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid one cycle after a read |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| passed | output | 1 | Sticky: last run found no fault |
| failed | output | 1 | Sticky: last run found a fault |
| fail_addr | output | ADDR_W | Address of the failing word |
| fail_expected | output | DATA_W | Value the failing word should have held |
| fail_actual | output | DATA_W | Value read from the failing word |
| fail_phase | output | 2 | Pass code at the failure (2 invert, 3 clear) |

## Verification
The bench builds the block with ADDR_W=8 and DATA_W=8 so that a full 256-word sweep is short. Such a sweep makes the incrementing value wrap to zero on the last word. A region whose high bound lies below its low bound then runs through address zero. A memory model with a stuck bit on one word can make the compare fail either in the invert pass or only in the clear pass, depending on the polarity of the stuck bit.

// File: rtl/mtest_pkg.sv
package mtest_pkg;

    // Pass codes; also the encoding of the fail_phase output.
    typedef enum logic [1:0] {
        PH_NONE   = 2'd0,
        PH_FILL   = 2'd1,
        PH_INVERT = 2'd2,
        PH_CLEAR  = 2'd3
    } phase_e;

    // Per-word step inside a pass.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_CHECK = 2'd2
    } step_e;

endpackage

// File: rtl/mtest_expect.sv
// Data the sequencer expects on a read and drives on a write, per pass.
module mtest_expect
    import mtest_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  phase_e              phase,
    input  logic [DATA_W-1:0]   pattern,
    output logic [DATA_W-1:0]   expect_rd,
    output logic [DATA_W-1:0]   write_val
);

    always_comb begin
        expect_rd = '0;
        write_val = '0;
        unique case (phase)
            PH_FILL: begin
                write_val = pattern;
            end
            PH_INVERT: begin
                expect_rd = pattern;
                write_val = ~pattern;
            end
            PH_CLEAR: begin
                expect_rd = ~pattern;
                write_val = '0;
            end
            default: begin
                expect_rd = '0;
                write_val = '0;
            end
        endcase
    end

endmodule

// File: rtl/mtest_walker.sv
// Address and pattern walker over the captured region.
module mtest_walker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              rewind,
    input  logic              advance,
    input  logic [ADDR_W-1:0] lo_in,
    input  logic [ADDR_W-1:0] hi_in,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] pattern,
    output logic              at_end
);

    localparam logic [DATA_W-1:0] PAT_FIRST = DATA_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
        logic [DATA_W-1:0] pat;
    } walk_t;

    walk_t walk_d, walk_q;

    always_comb begin
        walk_d = walk_q;
        if (load) begin
            walk_d.lo   = lo_in;
            walk_d.hi   = hi_in;
            walk_d.addr = lo_in;
            walk_d.pat  = PAT_FIRST;
        end else if (rewind) begin
            walk_d.addr = walk_q.lo;
            walk_d.pat  = PAT_FIRST;
        end else if (advance) begin
            walk_d.addr = walk_q.addr + ADDR_W'(1);
            walk_d.pat  = walk_q.pat + DATA_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_q <= '0;
        end else begin
            walk_q <= walk_d;
        end
    end

    assign addr    = walk_q.addr;
    assign pattern = walk_q.pat;
    assign at_end  = (walk_q.addr == walk_q.hi);

endmodule

// File: rtl/mtest_fault_log.sv
// Sticky outcome and first-failure record.
module mtest_fault_log #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              record,
    input  logic              mark_pass,
    input  logic [ADDR_W-1:0] rec_addr,
    input  logic [DATA_W-1:0] rec_expected,
    input  logic [DATA_W-1:0] rec_actual,
    input  logic [1:0]        rec_phase,
    output logic              passed,
    output logic              failed,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [DATA_W-1:0] fail_expected,
    output logic [DATA_W-1:0] fail_actual,
    output logic [1:0]        fail_phase
);

    typedef struct packed {
        logic              passed;
        logic              failed;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] expected;
        logic [DATA_W-1:0] actual;
        logic [1:0]        phase;
    } log_t;

    log_t log_d, log_q;

    always_comb begin
        log_d = log_q;
        if (clear) begin
            log_d = '0;
        end else if (record) begin
            log_d.failed   = 1'b1;
            log_d.addr     = rec_addr;
            log_d.expected = rec_expected;
            log_d.actual   = rec_actual;
            log_d.phase    = rec_phase;
        end else if (mark_pass) begin
            log_d.passed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            log_q <= '0;
        end else begin
            log_q <= log_d;
        end
    end

    assign passed        = log_q.passed;
    assign failed        = log_q.failed;
    assign fail_addr     = log_q.addr;
    assign fail_expected = log_q.expected;
    assign fail_actual   = log_q.actual;
    assign fail_phase    = log_q.phase;

    AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(passed && failed));                                         // R7
    AST_FAIL_IS_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        failed |-> (fail_expected != fail_actual));                   // R5
    AST_FAIL_PHASE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        failed |-> (fail_phase == 2'd2 || fail_phase == 2'd3));       // R5

endmodule

// File: rtl/mem_march_tester.sv
module mem_march_tester
    import mtest_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] region_lo,
    input  logic [ADDR_W-1:0] region_hi,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              passed,
    output logic              failed,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [DATA_W-1:0] fail_expected,
    output logic [DATA_W-1:0] fail_actual,
    output logic [1:0]        fail_phase
);

    typedef struct packed {
        step_e  step;
        phase_e phase;
        logic   done;
    } seq_t;

    seq_t seq_d, seq_q;

    logic              walk_load, walk_rewind, walk_adv, at_end;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_pat, exp_rd, wr_val;
    logic              log_clear, log_record, log_pass;
    logic              match;

    mtest_walker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) walker_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (walk_load),
        .rewind  (walk_rewind),
        .advance (walk_adv),
        .lo_in   (region_lo),
        .hi_in   (region_hi),
        .addr    (cur_addr),
        .pattern (cur_pat),
        .at_end  (at_end)
    );

    mtest_expect #(.DATA_W(DATA_W)) expect_i (
        .phase     (seq_q.phase),
        .pattern   (cur_pat),
        .expect_rd (exp_rd),
        .write_val (wr_val)
    );

    assign match = (mem_rdata == exp_rd);

    always_comb begin
        seq_d       = seq_q;
        seq_d.done  = 1'b0;
        walk_load   = 1'b0;
        walk_rewind = 1'b0;
        walk_adv    = 1'b0;
        log_clear   = 1'b0;
        log_record  = 1'b0;
        log_pass    = 1'b0;
        mem_en      = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = cur_addr;
        mem_wdata   = '0;
        unique case (seq_q.step)
            ST_IDLE: begin
                if (start) begin
                    walk_load   = 1'b1;
                    log_clear   = 1'b1;
                    seq_d.phase = PH_FILL;
                    seq_d.step  = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                mem_en = 1'b1;
                if (seq_q.phase == PH_FILL) begin
                    mem_we    = 1'b1;
                    mem_wdata = wr_val;
                    if (at_end) begin
                        walk_rewind = 1'b1;
                        seq_d.phase = PH_INVERT;
                    end else begin
                        walk_adv = 1'b1;
                    end
                end else begin
                    seq_d.step = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (match) begin
                    mem_en    = 1'b1;
                    mem_we    = 1'b1;
                    mem_wdata = wr_val;
                    if (!at_end) begin
                        walk_adv   = 1'b1;
                        seq_d.step = ST_ISSUE;
                    end else if (seq_q.phase == PH_INVERT) begin
                        walk_rewind = 1'b1;
                        seq_d.phase = PH_CLEAR;
                        seq_d.step  = ST_ISSUE;
                    end else begin
                        log_pass    = 1'b1;
                        seq_d.done  = 1'b1;
                        seq_d.phase = PH_NONE;
                        seq_d.step  = ST_IDLE;
                    end
                end else begin
                    log_record  = 1'b1;
                    seq_d.done  = 1'b1;
                    seq_d.phase = PH_NONE;
                    seq_d.step  = ST_IDLE;
                end
            end
            default: begin
                seq_d.step  = ST_IDLE;
                seq_d.phase = PH_NONE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{step: ST_IDLE, phase: PH_NONE, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy = (seq_q.step != ST_IDLE);
    assign done = seq_q.done;

    mtest_fault_log #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) log_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .clear         (log_clear),
        .record        (log_record),
        .mark_pass     (log_pass),
        .rec_addr      (cur_addr),
        .rec_expected  (exp_rd),
        .rec_actual    (mem_rdata),
        .rec_phase     (seq_q.phase),
        .passed        (passed),
        .failed        (failed),
        .fail_addr     (fail_addr),
        .fail_expected (fail_expected),
        .fail_actual   (fail_actual),
        .fail_phase    (fail_phase)
    );

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_en);                                           // R11
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                              // R6
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                              // R6
    AST_FILL_WRITES_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_FILL) |-> (mem_en && mem_we));             // R2
    AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && seq_q.phase != PH_FILL)
            |-> ($past(mem_en) && !$past(mem_we) && $past(mem_addr) == mem_addr)); // R3
    AST_OUTCOME_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (passed || failed));                                 // R7

endmodule

// File: tb/mem_march_tester_tb.sv
`timescale 1ns/1ps
module mem_march_tester_tb_top;

    localparam int AW = 8;
    localparam int DW = 8;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] region_lo = '0;
    logic [AW-1:0] region_hi = '0;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          busy, done, passed, failed;
    logic [AW-1:0] fail_addr;
    logic [DW-1:0] fail_expected, fail_actual;
    logic [1:0]    fail_phase;

    always #2.5 clk = ~clk;

    mem_march_tester #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .region_lo(region_lo), .region_hi(region_hi),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .passed(passed), .failed(failed),
        .fail_addr(fail_addr), .fail_expected(fail_expected),
        .fail_actual(fail_actual), .fail_phase(fail_phase)
    );

    // Memory model with an optional stuck-bit fault on one word (read side).
    logic [DW-1:0] ram [NW];
    bit            flt_on = 0;
    int            flt_addr = 0;
    logic [DW-1:0] flt_mask = '0;
    logic [DW-1:0] flt_val = '0;

    function automatic logic [DW-1:0] faulty(int a, logic [DW-1:0] v);
        if (flt_on && a == flt_addr) return (v & ~flt_mask) | (flt_val & flt_mask);
        return v;
    endfunction

    always @(posedge clk) begin
        if (mem_en && mem_we) ram[mem_addr] <= mem_wdata;
        if (mem_en && !mem_we) mem_rdata <= faulty(int'(mem_addr), ram[mem_addr]);
    end

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    typedef struct { bit en; bit we; int addr; int data; } op_t;

    // Behavioural model: builds the per-cycle bus trace and the outcome.
    task automatic run(int lo, int hi, int poke, string name);
        op_t q[$];
        logic [DW-1:0] mm [NW];
        int n, a, e, w, v;
        bit bad = 0;
        int f_addr = 0, f_exp = 0, f_act = 0, f_ph = 0;
        n = ((hi - lo) & (NW - 1)) + 1;                        // R1
        for (int i = 0; i < NW; i++) mm[i] = ram[i];
        for (int k = 0; k < n; k++) begin                      // R2
            a = (lo + k) & (NW - 1);
            q.push_back('{1, 1, a, (k + 1) & (NW - 1)});
            mm[a] = DW'(k + 1);
        end
        for (int ph = 2; ph <= 3 && !bad; ph++) begin          // R3 R4
            for (int k = 0; k < n && !bad; k++) begin
                a = (lo + k) & (NW - 1);
                e = (ph == 2) ? ((k + 1) & 255) : (~(k + 1) & 255);
                w = (ph == 2) ? (~(k + 1) & 255) : 0;
                q.push_back('{1, 0, a, 0});
                v = int'(faulty(a, mm[a]));
                if (v != e) begin                              // R5
                    q.push_back('{0, 0, 0, 0});
                    bad = 1; f_addr = a; f_exp = e; f_act = v; f_ph = ph;
                end else begin
                    q.push_back('{1, 1, a, w});
                    mm[a] = DW'(w);
                end
            end
        end
        @(negedge clk);
        region_lo = AW'(lo); region_hi = AW'(hi); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < q.size(); i++) begin
            bit ok;
            ok = (mem_en == q[i].en) && busy && !done && !passed && !failed;
            if (ok && q[i].en)
                ok = (mem_we == q[i].we) && (int'(mem_addr) == q[i].addr)
                     && (!q[i].we || int'(mem_wdata) == q[i].data);
            chk(ok, "R2/R3/R4/R8", {name, " bus cycle"},
                {mem_en, mem_we, 6'd0, mem_addr, mem_wdata},
                {q[i].en, q[i].we, 6'd0, q[i].addr[7:0], q[i].data[7:0]});
            if (i == poke) begin                               // R8: ignored while busy
                start = 1'b1; region_lo = 8'h00; region_hi = 8'h01;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(done && !busy, "R6", {name, " done pulse"}, {done, busy}, 2);
        chk(passed == !bad && failed == bad, "R7", {name, " outcome"},
            {passed, failed}, {!bad, bad});
        chk(int'(fail_addr) == f_addr && int'(fail_expected) == f_exp &&
            int'(fail_actual) == f_act && int'(fail_phase) == f_ph, "R5",
            {name, " fail record"},
            {fail_phase, fail_addr, fail_expected, fail_actual},
            {f_ph[1:0], f_addr[7:0], f_exp[7:0], f_act[7:0]});
        @(negedge clk);
        chk(!done && !busy && !mem_en && passed == !bad && failed == bad, "R7",
            {name, " sticky after done"}, {done, busy, mem_en, passed, failed},
            {3'b000, !bad, bad});
        if (!bad) begin
            int nz = 0;
            for (int k = 0; k < n; k++) if (ram[(lo + k) & (NW - 1)] != '0) nz++;
            chk(nz == 0, "R9", {name, " region cleared"}, nz, 0);
        end
    endtask

    initial begin
        for (int i = 0; i < NW; i++) ram[i] = DW'(i ^ 8'h5A);
        repeat (4) @(negedge clk);
        chk(!busy && !done && !passed && !failed && !mem_en, "R10", "reset state",
            {busy, done, passed, failed, mem_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_en, "R11", "idle quiet", {busy, mem_en}, 0);
        run(10, 20, -1, "R1 basic region");
        run(5, 5, -1, "R1 single word");
        run(0, 255, -1, "R2 full sweep with pattern wrap");
        run(250, 3, -1, "R1 address wrap");
        run(30, 45, 7, "R8 start while busy");
        flt_on = 1; flt_addr = 12; flt_mask = 8'h01; flt_val = 8'h00;
        run(10, 20, -1, "R5 stuck-low in invert pass");
        flt_val = 8'h01;
        run(10, 20, -1, "R5 stuck-high in clear pass");
        flt_addr = 40; flt_mask = 8'h80; flt_val = 8'h00;
        run(35, 44, -1, "R4 stuck-low top bit");
        flt_on = 0;
        run(60, 70, -1, "R7 pass after fail clears record");
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL R6 watchdog: actual 0x0 expected 0x1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule